// File: doc/BRIEF.md
# Watchdog Wake Timer Controller

This block is a low-power interval timer with a supervisory watchdog. It runs from a slow oscillator and is clocked at twice that oscillator's rate, so each clock is one half-cycle tick. A 3-bit select chooses one of eight period lengths. At the end of every period the block emits a pulse: a wake pulse when the attached processor showed it was alive during that period, or an active-low reset pulse when it did not. Both pulses carry a calibration pulse that is exactly one oscillator cycle wide, which lets software measure the true oscillator period.

The processor shows it is alive by driving a rising edge on the done input. A power-good input gates the timer. While power-good is low, all outputs are held idle and all timing state is cleared. When power-good returns, the counters restart from zero. The first period after power returns always ends in a reset pulse, because the power drop is remembered until then. Both the done input and the power-good input are synchronised to the tick clock.

Top module: `wake_watchdog_timer`

## Requirements
- R1: Period length in ticks is twice the oscillator-cycle count that the select gives: 0→64, 1→128, 2→256, 3→512, 4→640, 5→1024, 6→2048, 7→4096. Counting starts when the synchronised power-good rises (2 ticks after the pin rises). The first pulse begins P+2 ticks after the pin rises, where P is the period in ticks.
- R2: A period ends in a wake pulse when a valid done edge was seen during that period. It ends in a reset pulse when no valid done edge was seen. An edge detected on the same tick as the period end counts toward the period that is ending.
- R3: A valid done is a low-to-high transition, seen 2 ticks after the pin rises. Further edges within the same period change nothing, and no done edge restarts the period counter.
- R4: The wake pulse is high for 4 ticks (2 oscillator cycles). The reset output is low for 2 ticks (1 oscillator cycle). The two are never active together.
- R5: The calibration output rises 1 tick after the wake pulse or reset pulse begins, and stays high for 2 ticks.
- R6: A valid done edge seen while the wake or calibration output is high ends the sequence on the next tick, with wake low, calibration low and the reset output high.
- R7: While power-good or the block reset is low, wake and calibration are low and the reset output is high. A falling power-good forces this state asynchronously and stops timing.
- R8: The first period after power-good rises ends in a reset pulse, even when a valid done edge arrives during it.
- R9: The period select is captured while power is down and held for the whole powered interval. Changes to the select during that interval have no effect on period length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock at twice the oscillator rate |
| rstN | input | 1 | Block reset, active low, asynchronous |
| powerGood | input | 1 | Power-good level; low holds the timer idle |
| doneIn | input | 1 | Processor alive indication, rising edge is valid |
| periodSel | input | 3 | Period select code |
| wakeOut | output | 1 | Wake pulse, active high |
| calOut | output | 1 | Calibration pulse, one oscillator cycle wide |
| resetOutN | output | 1 | Reset pulse, active low |

## Verification
Every result has a fixed latency in ticks. A power-good rise takes effect after 2 ticks, through the release synchroniser. A done edge takes effect after 3 ticks, through two synchroniser stages and the edge register. The first pulse starts P+2 ticks after power-good rises. Calibration starts one tick into a pulse. A power-good fall acts within the same tick. The bench drives inputs 2 ns after a falling clock edge. A behavioural model, built on these latencies, advances on each rising edge. At every falling edge, the three outputs are compared with the model. Power-drop checks also sample 1 ns after the fall, to confirm the asynchronous path.

// File: rtl/wwt_pkg.sv
package wwt_pkg;
  // control -> datapath strobes
  typedef struct packed {
    logic seqStart;
    logic seqStop;
  } seqCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic       periodEnd;
    logic       active;
    logic [1:0] phase;
  } seqStat_t;
endpackage

// File: rtl/wwt_sync.sv
module wwt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/wwt_datapath.sv
module wwt_datapath
  import wwt_pkg::*;
#(
  parameter int BASE_CYCLES   = 64,
  parameter int TEN_MULT      = 10,
  parameter int TICKS_PER_CYC = 2,
  localparam int CNT_W = $clog2(BASE_CYCLES * 64 * TICKS_PER_CYC)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrOk,
  input  logic [2:0] periodSel,
  input  seqCmd_t    cmd,
  output seqStat_t   stat
);
  logic [2:0]       selQ;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastTick;
  logic [CNT_W-1:0] limTab [8];
  logic             active;
  logic [1:0]       phase;

  for (genvar i = 0; i < 8; i++) begin : g_lim
    localparam int CYC = (i < 4) ? (BASE_CYCLES << i) :
                         (i == 4) ? (BASE_CYCLES * TEN_MULT) :
                                    (BASE_CYCLES << (i - 1));
    assign limTab[i] = CNT_W'(CYC * TICKS_PER_CYC - 1);
  end

  // select tracks the pins while power is down, frozen once up
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       selQ <= '0;
    else if (!pwrOk) selQ <= periodSel;
  end

  assign lastTick = limTab[selQ];

  always_ff @(posedge clk or negedge pwrOk) begin
    if (!pwrOk)                 cnt <= '0;
    else if (cnt == lastTick)   cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge pwrOk) begin
    if (!pwrOk) begin
      active <= 1'b0;
      phase  <= 2'd0;
    end else if (cmd.seqStart) begin
      active <= 1'b1;
      phase  <= 2'd0;
    end else if (cmd.seqStop) begin
      active <= 1'b0;
    end else if (active) begin
      phase <= phase + 2'd1;
    end
  end

  assign stat.periodEnd = (cnt == lastTick);
  assign stat.active    = active;
  assign stat.phase     = phase;

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!pwrOk)
    cnt <= lastTick);

  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (!pwrOk)
    $past(pwrOk) |-> $stable(selQ));
endmodule

// File: rtl/wwt_control.sv
module wwt_control
  import wwt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     pwrOk,
  input  logic     doneIn,
  input  seqStat_t stat,
  output seqCmd_t  cmd,
  output logic     wakeOut,
  output logic     calOut,
  output logic     resetOutN
);
  logic       doneS;
  logic       doneD;
  logic       doneEdge;
  logic       doneSeen;
  logic       pwrFlag;
  logic       isWake;
  logic       abortSeq;
  logic [1:0] lastPh;

  wwt_sync #(.STAGES(SYNC_STAGES)) u_doneSync (
    .clk(clk), .arstN(pwrOk), .d(doneIn), .q(doneS)
  );

  always_ff @(posedge clk or negedge pwrOk) begin
    if (!pwrOk) doneD <= 1'b0;
    else        doneD <= doneS;
  end

  assign doneEdge = doneS & ~doneD;

  always_ff @(posedge clk or negedge pwrOk) begin
    if (!pwrOk) begin
      doneSeen <= 1'b0;
      pwrFlag  <= 1'b1;
      isWake   <= 1'b0;
    end else if (stat.periodEnd) begin
      isWake   <= (doneSeen | doneEdge) & ~pwrFlag;
      doneSeen <= 1'b0;
      pwrFlag  <= 1'b0;
    end else if (doneEdge) begin
      doneSeen <= 1'b1;
    end
  end

  assign wakeOut   = stat.active & isWake;
  assign calOut    = stat.active & (stat.phase == 2'd1 || stat.phase == 2'd2);
  assign resetOutN = ~(stat.active & ~isWake & (stat.phase <= 2'd1));

  assign abortSeq     = doneEdge & (wakeOut | calOut);
  assign lastPh       = isWake ? 2'd3 : 2'd2;
  assign cmd.seqStart = stat.periodEnd;
  assign cmd.seqStop  = stat.active & ~stat.periodEnd &
                        (abortSeq | (stat.phase == lastPh));

  // R4
  wake_rst_excl_chk: assert property (@(posedge clk) disable iff (!pwrOk)
    !(wakeOut && !resetOutN));

  // R5
  cal_follow_chk: assert property (@(posedge clk) disable iff (!pwrOk)
    $rose(calOut) |-> ($past(wakeOut) || !$past(resetOutN)));

  // R8
  drop_forces_reset_chk: assert property (@(posedge clk) disable iff (!pwrOk)
    (stat.periodEnd && pwrFlag) |=> (!wakeOut && !resetOutN));

  // R6
  abort_idle_chk: assert property (@(posedge clk) disable iff (!pwrOk)
    (doneEdge && (wakeOut || calOut) && !stat.periodEnd) |=>
      (!wakeOut && !calOut && resetOutN));
endmodule

// File: rtl/wake_watchdog_timer.sv
module wake_watchdog_timer
  import wwt_pkg::*;
#(
  parameter int BASE_CYCLES   = 64,
  parameter int TEN_MULT      = 10,
  parameter int TICKS_PER_CYC = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerGood,
  input  logic       doneIn,
  input  logic [2:0] periodSel,
  output logic       wakeOut,
  output logic       calOut,
  output logic       resetOutN
);
  logic     pwrClrN;
  logic     pwrOk;
  seqCmd_t  cmd;
  seqStat_t stat;

  assign pwrClrN = rstN & powerGood;

  // asynchronous clear on power drop, synchronous release
  wwt_sync #(.STAGES(SYNC_STAGES)) u_pwrSync (
    .clk(clk), .arstN(pwrClrN), .d(1'b1), .q(pwrOk)
  );

  wwt_datapath #(
    .BASE_CYCLES(BASE_CYCLES), .TEN_MULT(TEN_MULT), .TICKS_PER_CYC(TICKS_PER_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .pwrOk(pwrOk), .periodSel(periodSel),
    .cmd(cmd), .stat(stat)
  );

  wwt_control #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk(clk), .pwrOk(pwrOk), .doneIn(doneIn), .stat(stat), .cmd(cmd),
    .wakeOut(wakeOut), .calOut(calOut), .resetOutN(resetOutN)
  );
endmodule

// File: tb/wake_watchdog_timer_tb_top.sv
`timescale 1ns/1ps
module wake_watchdog_timer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       powerGood = 1'b0;
  logic       doneIn = 1'b0;
  logic [2:0] periodSel = 3'd0;
  logic       wakeOut, calOut, resetOutN;

  int    nTests = 0;
  int    nFail  = 0;
  string curReq = "R7";
  bit    finished = 0;

  // behavioural model state
  int mS1 = 0, mOk = 0, mCnt = 0, mAct = 0, mPh = 0, mIsW = 0;
  int mPf = 1, mDs = 0, mA = 0, mB = 0, mC = 0, mSel = 0;

  // window counters
  int wakeTicks = 0, calTicks = 0, rstTicks = 0, sinceUp = 0, firstRst = -1;

  always #10 clk = ~clk;

  wake_watchdog_timer dut_i (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .doneIn(doneIn),
    .periodSel(periodSel), .wakeOut(wakeOut), .calOut(calOut), .resetOutN(resetOutN)
  );

  function automatic int periodTicks(int s);
    int cyc;
    if (s < 4)       cyc = 64 << s;
    else if (s == 4) cyc = 640;
    else             cyc = 64 << (s - 1);
    return 2 * cyc;
  endfunction

  function automatic bit modelPwr();
    return rstN && powerGood;
  endfunction
  function automatic bit mWake();
    return modelPwr() && mAct != 0 && mIsW != 0;
  endfunction
  function automatic bit mCal();
    return modelPwr() && mAct != 0 && (mPh == 1 || mPh == 2);
  endfunction
  function automatic bit mRstN();
    return !(modelPwr() && mAct != 0 && mIsW == 0 && mPh <= 1);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // model update on every rising edge, from pin values
  always @(posedge clk) begin
    if (!rstN || !powerGood) begin
      mS1 = 0; mOk = 0; mCnt = 0; mAct = 0; mPh = 0; mIsW = 0;
      mPf = 1; mDs = 0; mA = 0; mB = 0; mC = 0;
      mSel = rstN ? int'(periodSel) : 0;
    end else begin
      if (mOk == 0) mSel = int'(periodSel);
      else begin
        int edgeD, wakeO, calO, endS;
        edgeD = (mB != 0 && mC == 0) ? 1 : 0;
        wakeO = mWake();
        calO  = mCal();
        mC = mB; mB = mA; mA = doneIn;
        endS = (mCnt == periodTicks(mSel) - 1) ? 1 : 0;
        mCnt = endS ? 0 : mCnt + 1;
        if (endS) begin
          mAct = 1; mPh = 0;
          mIsW = ((mDs != 0 || edgeD != 0) && mPf == 0) ? 1 : 0;
          mPf = 0; mDs = 0;
        end else begin
          if (mAct != 0) begin
            if (edgeD != 0 && (wakeO || calO)) mAct = 0;
            else if (mPh == 3 || (mIsW == 0 && mPh == 2)) mAct = 0;
            else mPh++;
          end
          if (edgeD != 0) mDs = 1;
        end
      end
      mOk = mS1; mS1 = 1;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!finished) begin
      check(curReq, "wakeOut",   wakeOut,   mWake());
      check(curReq, "calOut",    calOut,    mCal());
      check(curReq, "resetOutN", resetOutN, mRstN());
      if (wakeOut)    wakeTicks++;
      if (calOut)     calTicks++;
      if (!resetOutN) rstTicks++;
      sinceUp++;
      if (!resetOutN && firstRst < 0) firstRst = sinceUp;
    end
  end

  task automatic clearWin();
    wakeTicks = 0; calTicks = 0; rstTicks = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #2;
  endtask

  task automatic pulseDone();
    doneIn = 1'b1; ticks(4); doneIn = 1'b0;
  endtask

  task automatic powerUp(int sel);
    periodSel = 3'(sel);
    ticks(1);
    powerGood = 1'b1;
    sinceUp = 0; firstRst = -1;
  endtask

  // watchdog
  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    // R7: reset / power-down state
    ticks(3);
    check("R7", "wake idle in reset", wakeOut, 0);
    check("R7", "reset idle in reset", resetOutN, 1);
    rstN = 1'b1;
    ticks(5);
    check("R7", "cal idle while power low", calOut, 0);

    // R1 / R4 / R5: no done, period ends in reset
    curReq = "R1";
    powerUp(0);
    clearWin();
    ticks(140);
    check("R1", "first reset tick after power-up (sel 0)", firstRst, 130);
    check("R4", "reset low ticks", rstTicks, 2);
    check("R5", "cal high ticks after reset", calTicks, 2);
    check("R2", "no wake without done", wakeTicks, 0);

    // R2: done in period gives wake
    curReq = "R2";
    clearWin();
    pulseDone();
    ticks(130);
    check("R2", "wake after done", wakeTicks, 4);
    check("R4", "no reset when done seen", rstTicks, 0);
    check("R5", "cal high ticks after wake", calTicks, 2);

    // R2: missed done gives reset again
    clearWin();
    ticks(128);
    check("R2", "reset after missed done", rstTicks, 2);

    // R3: two done edges in one period, counter not restarted
    curReq = "R3";
    clearWin();
    ticks(20);
    pulseDone();
    ticks(30);
    pulseDone();
    ticks(80);
    check("R3", "single wake for repeated done", wakeTicks, 4);

    // R6: done while wake high cuts the sequence
    curReq = "R6";
    pulseDone();
    clearWin();
    while (!wakeOut) ticks(1);
    doneIn = 1'b1;
    ticks(8);
    doneIn = 1'b0;
    check("R6", "wake cut short", wakeTicks, 3);

    // R9: select change while powered ignored
    curReq = "R9";
    periodSel = 3'd7;
    clearWin();
    ticks(132);
    check("R9", "period unchanged after select change", rstTicks + wakeTicks > 0, 1);

    // R7: power drop during wake forces idle asynchronously
    curReq = "R7";
    pulseDone();
    while (!wakeOut) ticks(1);
    powerGood = 1'b0;
    #1;
    check("R7", "wake forced low on power drop", wakeOut, 0);
    check("R7", "reset high on power drop", resetOutN, 1);
    ticks(10);

    // R8 / R1: power returns with sel 4, done ignored for first period
    curReq = "R8";
    powerUp(4);
    clearWin();
    ticks(50);
    pulseDone();
    ticks(1240);
    check("R1", "first reset tick after power-up (sel 4)", firstRst, 1282);
    check("R8", "reset after power return despite done", rstTicks, 2);
    check("R8", "no wake in first period", wakeTicks, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule